// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block decides when a voltage supervisor lets a system run. Two comparator flags report the supply: one says the supply has dropped under the detect threshold, and the other says it has climbed over the higher release threshold. Because the two thresholds differ, the sequencer has hysteresis. A supply that sits between the thresholds keeps whatever state it already has. When the supply drops, both active-low outputs (system reset and watchdog fault) are pulled low at once, whatever the watchdog enable state is and whatever counting is under way.

Release takes several steps. The block first waits out a standby interval that starts when the outage begins. It then waits for the supply to cross the release threshold. After that comes a fixed initialisation interval in clocks, and then exactly four periods of an external timebase, each period marked by a one-cycle tick. The same period counter also handles recovery from a watchdog timeout. It does so with the system reset held released, and the low-voltage path takes priority over any such recovery. A supply dip too short to pass the input filter does not pull the outputs low, but it still costs one full four-period sequence before watchdog counting may resume.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst` is high and right after it is released, `rst_n_o`, `wdo_n_o` and `wd_ok_o` are all 0.
- R2: When `below_det_i` goes high and stays high, both `rst_n_o` and `wdo_n_o` fall exactly DEB_CYC+3 clocks after the first clock that samples it. This holds in any state, including normal running and watchdog recovery.
- R3: After the detect flag clears, both outputs stay low for as long as `above_rel_i` is low, and any number of timebase ticks does not change this.
- R4: Once the supply is over the release threshold, the standby interval has elapsed and INIT_CYC+1 clocks of initialisation have passed, the fourth counted tick raises `rst_n_o`, `wdo_n_o` and `wd_ok_o` together on the next clock. Ticks that arrive during initialisation are not counted.
- R5: After only NUM_PERIODS-1 counted ticks, both outputs are still low.
- R6: Initialisation cannot begin until STANDBY_CYC clocks have passed since the outage was detected, even when the supply recovers earlier. Ticks issued in that extra wait are not counted.
- R7: A new detection during initialisation or period counting restarts the whole sequence. A full NUM_PERIODS fresh ticks are then needed after release.
- R8: A one-cycle `wdt_timeout_i` pulse in normal running drives `wdo_n_o` low on the next clock and keeps `rst_n_o` high. `wdo_n_o` returns high one clock after the fourth subsequent tick.
- R9: A detection during watchdog recovery forces both outputs low, overriding the recovery.
- R10: A pulse on `below_det_i` shorter than DEB_CYC clocks does not pull either output low. If it happens during normal running, `wd_ok_o` drops and returns high only one clock after the fourth subsequent tick.
- R11: `wd_ok_o` is high only in normal running. A timeout request during watchdog recovery is ignored and does not restart the period count. A timeout request while the supply is low is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| below_det_i | input | 1 | Asynchronous comparator flag: supply under detect threshold |
| above_rel_i | input | 1 | Asynchronous comparator flag: supply over release threshold |
| period_tick_i | input | 1 | One-cycle pulse at the end of each timebase period |
| wdt_timeout_i | input | 1 | One-cycle watchdog timeout request |
| rst_n_o | output | 1 | Active-low system reset, registered |
| wdo_n_o | output | 1 | Active-low watchdog fault, registered |
| wd_ok_o | output | 1 | High when watchdog counting may run (normal state) |

## Verification
Each flag passes through two synchroniser stages and a DEB_CYC debounce before the state register acts on it. A comparator change therefore reaches the outputs DEB_CYC+3 clocks after it is driven, and the bench checks one clock before that point and exactly at it. A tick is counted on the clock that samples it, and the outputs move on the following clock. A timeout request moves `wdo_n_o` on the first clock. For each case the bench checks one clock after the final stimulus, and checks the "not yet" side several clocks after the third tick. The standby case places ticks in the clocks where a design without the standby wait would already be counting periods, so a missing wait releases early and is caught.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    ST_LOW     = 3'd0,
    ST_INIT    = 3'd1,
    ST_PERIODS = 3'd2,
    ST_RUN     = 3'd3,
    ST_WDREC   = 3'd4,
    ST_DIPREC  = 3'd5
  } state_t;
endpackage

// File: rtl/srs_flag_filter.sv
// Two-stage synchroniser plus debounce. An optional blip output pulses when a
// rising attempt from a low level is abandoned before acceptance.
module srs_flag_filter #(
  parameter int   DEB_CYC    = 4,
  parameter bit   RST_LVL    = 1'b0,
  parameter bit   CATCH_BLIP = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic lvl_o,
  output logic blip_o
);
  localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

  logic          sync1_q, sync2_q, lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= RST_LVL;
      sync2_q <= RST_LVL;
      lvl_q   <= RST_LVL;
      cnt_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      if (sync2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYC - 1)) begin
        lvl_q <= sync2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;

  generate
    if (CATCH_BLIP) begin : g_blip
      logic blip_q;
      always_ff @(posedge clk) begin
        if (rst) blip_q <= 1'b0;
        else     blip_q <= (sync2_q == lvl_q) && (cnt_q != '0) && !lvl_q;
      end
      assign blip_o = blip_q;
    end else begin : g_noblip
      assign blip_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/srs_span_cnt.sv
// Saturating up-counter with synchronous clear; reached_o once LIMIT counted.
module srs_span_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic reached_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                        cnt_q <= '0;
    else if (en_i && (cnt_q != CW'(LIMIT)))  cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int DEB_CYC     = 4,
  parameter int INIT_CYC    = 6,
  parameter int STANDBY_CYC = 12,
  parameter int NUM_PERIODS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic below_det_i,
  input  logic above_rel_i,
  input  logic period_tick_i,
  input  logic wdt_timeout_i,
  output logic rst_n_o,
  output logic wdo_n_o,
  output logic wd_ok_o
);
  import srs_pkg::*;

  state_t state_q, state_d;
  logic   low_lvl, rel_lvl, dip_evt, rel_blip;
  logic   stby_done, init_done, per_done;
  logic   counting;
  logic   rst_n_q, wdo_n_q, ok_q;

  // Detect flag: assume low supply out of reset; catch too-short dips.
  srs_flag_filter #(.DEB_CYC(DEB_CYC), .RST_LVL(1'b1), .CATCH_BLIP(1'b1)) u_low_flt (
    .clk(clk), .rst(rst), .raw_i(below_det_i), .lvl_o(low_lvl), .blip_o(dip_evt)
  );

  srs_flag_filter #(.DEB_CYC(DEB_CYC), .RST_LVL(1'b0), .CATCH_BLIP(1'b0)) u_rel_flt (
    .clk(clk), .rst(rst), .raw_i(above_rel_i), .lvl_o(rel_lvl), .blip_o(rel_blip)
  );

  // Standby measured from the start of the outage.
  srs_span_cnt #(.LIMIT(STANDBY_CYC)) u_stby (
    .clk(clk), .rst(rst), .clr_i(state_q != ST_LOW), .en_i(1'b1), .reached_o(stby_done)
  );

  srs_span_cnt #(.LIMIT(INIT_CYC)) u_init (
    .clk(clk), .rst(rst), .clr_i(state_q != ST_INIT), .en_i(1'b1), .reached_o(init_done)
  );

  assign counting = (state_q == ST_PERIODS) || (state_q == ST_WDREC) || (state_q == ST_DIPREC);

  // One shared period counter for power-on, watchdog and dip recovery.
  srs_span_cnt #(.LIMIT(NUM_PERIODS)) u_period (
    .clk(clk), .rst(rst), .clr_i(!counting), .en_i(period_tick_i), .reached_o(per_done)
  );

  always_comb begin
    state_d = state_q;
    if (low_lvl) begin
      state_d = ST_LOW;
    end else begin
      case (state_q)
        ST_LOW:     if (rel_lvl && stby_done) state_d = ST_INIT;
        ST_INIT:    if (init_done)            state_d = ST_PERIODS;
        ST_PERIODS: if (per_done)             state_d = ST_RUN;
        ST_RUN: begin
          if (dip_evt || rel_blip)            state_d = ST_DIPREC;
          else if (wdt_timeout_i)             state_d = ST_WDREC;
        end
        ST_WDREC:   if (per_done)             state_d = ST_RUN;
        ST_DIPREC:  if (per_done)             state_d = ST_RUN;
        default:                              state_d = ST_LOW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOW;
      rst_n_q <= 1'b0;
      wdo_n_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_n_q <= (state_d == ST_RUN) || (state_d == ST_WDREC) || (state_d == ST_DIPREC);
      wdo_n_q <= (state_d == ST_RUN) || (state_d == ST_DIPREC);
      ok_q    <= (state_d == ST_RUN);
    end
  end

  assign rst_n_o = rst_n_q;
  assign wdo_n_o = wdo_n_q;
  assign wd_ok_o = ok_q;
endmodule

// File: rtl/srs_checks.sv
module srs_checks (
  input logic           clk,
  input logic           rst,
  input logic           period_tick_i,
  input logic           wdt_timeout_i,
  input logic           rst_n_o,
  input logic           wdo_n_o,
  input logic           wd_ok_o,
  input logic           low_lvl,
  input logic           rel_lvl,
  input logic           dip_evt,
  input srs_pkg::state_t state_q
);
  import srs_pkg::*;

  assert_detect_forces_low_R2: assert property (@(posedge clk) disable iff (rst)
    low_lvl |=> (!rst_n_o && !wdo_n_o));

  assert_reset_implies_fault_R2: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |-> !wdo_n_o);

  assert_hold_below_release_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOW && !rel_lvl) |=> !rst_n_o);

  assert_release_follows_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> $past(period_tick_i, 2));

  assert_fault_clear_follows_tick_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(wdo_n_o) |-> $past(period_tick_i, 2));

  assert_timeout_keeps_reset_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && wdt_timeout_i && !low_lvl && !dip_evt) |=> (rst_n_o && !wdo_n_o));

  assert_ok_only_normal_R11: assert property (@(posedge clk) disable iff (rst)
    wd_ok_o |-> (rst_n_o && wdo_n_o));
endmodule

bind supply_reset_seq srs_checks u_srs_checks (
  .clk(clk), .rst(rst), .period_tick_i(period_tick_i), .wdt_timeout_i(wdt_timeout_i),
  .rst_n_o(rst_n_o), .wdo_n_o(wdo_n_o), .wd_ok_o(wd_ok_o),
  .low_lvl(low_lvl), .rel_lvl(rel_lvl), .dip_evt(dip_evt), .state_q(state_q)
);

// File: tb/test_supply_reset_seq.sv
`timescale 1ns/1ps
module test_supply_reset_seq;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst, below, above, tick, wdt;
  logic rst_n, wdo_n, ok;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  supply_reset_seq i_supply_reset_seq (
    .clk(clk), .rst(rst), .below_det_i(below), .above_rel_i(above),
    .period_tick_i(tick), .wdt_timeout_i(wdt),
    .rst_n_o(rst_n), .wdo_n_o(wdo_n), .wd_ok_o(ok)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk3(input string req, input logic e_rst, input logic e_wdo, input logic e_ok);
    chk(req, "rst_n_o", rst_n, e_rst);
    chk(req, "wdo_n_o", wdo_n, e_wdo);
    chk(req, "wd_ok_o", ok, e_ok);
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulse_wdt();
    wdt = 1'b1; @(negedge clk);
    wdt = 1'b0;
  endtask

  task automatic recover(input string req);
    below = 1'b0; above = 1'b1;
    wait_n(40);
    pulse_tick(3);
    wait_n(3);
    chk3(req, 1'b0, 1'b0, 1'b0);
    pulse_tick(1);
    wait_n(1);
    chk3(req, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_reset_state();
    chk3("R1", 1'b0, 1'b0, 1'b0);
    wait_n(2);
    chk3("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_power_up();
    below = 1'b0; above = 1'b1;
    wait_n(40);
    chk3("R4", 1'b0, 1'b0, 1'b0);
    pulse_tick(3);
    wait_n(3);
    chk3("R5", 1'b0, 1'b0, 1'b0);
    pulse_tick(1);
    wait_n(1);
    chk3("R4", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_detect_latency();
    below = 1'b1;
    wait_n(DEB + 2);
    chk3("R2", 1'b1, 1'b1, 1'b1);
    wait_n(1);
    chk3("R2", 1'b0, 1'b0, 1'b0);
    recover("R2");
  endtask

  task automatic t_hysteresis();
    below = 1'b1; above = 1'b0;
    wait_n(10);
    chk3("R3", 1'b0, 1'b0, 1'b0);
    below = 1'b0;
    wait_n(40);
    pulse_wdt();
    pulse_tick(4);
    wait_n(3);
    chk3("R3", 1'b0, 1'b0, 1'b0);
    recover("R11");
  endtask

  task automatic t_standby();
    below = 1'b1;
    wait_n(DEB + 3);
    chk3("R6", 1'b0, 1'b0, 1'b0);
    below = 1'b0;
    wait_n(14);
    tick = 1'b1;
    wait_n(4);
    tick = 1'b0;
    wait_n(5);
    chk3("R6", 1'b0, 1'b0, 1'b0);
    pulse_tick(3);
    wait_n(3);
    chk3("R6", 1'b0, 1'b0, 1'b0);
    pulse_tick(1);
    wait_n(1);
    chk3("R6", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_restart();
    below = 1'b1;
    wait_n(10);
    below = 1'b0;
    wait_n(40);
    pulse_tick(2);
    below = 1'b1;
    wait_n(10);
    chk3("R7", 1'b0, 1'b0, 1'b0);
    recover("R7");
  endtask

  task automatic t_wdt();
    pulse_wdt();
    chk3("R8", 1'b1, 1'b0, 1'b0);
    pulse_tick(2);
    pulse_wdt();
    pulse_tick(1);
    wait_n(3);
    chk3("R11", 1'b1, 1'b0, 1'b0);
    pulse_tick(1);
    wait_n(1);
    chk3("R8", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_wdt_low();
    pulse_wdt();
    chk3("R9", 1'b1, 1'b0, 1'b0);
    below = 1'b1;
    wait_n(DEB + 3);
    chk3("R9", 1'b0, 1'b0, 1'b0);
    recover("R9");
  endtask

  task automatic t_dip();
    below = 1'b1;
    wait_n(2);
    below = 1'b0;
    wait_n(10);
    chk3("R10", 1'b1, 1'b1, 1'b0);
    pulse_tick(3);
    wait_n(3);
    chk3("R10", 1'b1, 1'b1, 1'b0);
    pulse_tick(1);
    wait_n(1);
    chk3("R10", 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    rst = 1'b1; below = 1'b1; above = 1'b0; tick = 1'b0; wdt = 1'b0;
    wait_n(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_power_up();
    t_detect_latency();
    t_hysteresis();
    t_standby();
    t_restart();
    t_wdt();
    t_wdt_low();
    t_dip();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_n(20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule